// File: doc/BRIEF.md
# Hybrid Fixed-Plus-LRU Bus Arbiter

This block decides which of five requesters owns a shared bus: four external devices (indices 0 to 3) and the local host controller (index 4). One requester, device 0 by default, always outranks the others. The remaining four are ranked by a least-recently-granted list. Whenever one of them finishes a transfer, it moves to the back of that list. The others keep their relative positions.

Each requester raises its bit of `req_i`. The arbiter answers with a one-hot `gnt_o`. The owner keeps the bus until the `xfer_done_i` strobe is sampled. The list is updated on that same edge, and the next grant is chosen from the updated list. There is no data path, so all pins are plain control levels and strobes. Nothing at the edge of the block applies back-pressure.

Top module: `hybrid_bus_arbiter`

## Requirements
- R1: After reset `gnt_o` is all-zero and the rotating order, from first to last, is device 1, device 2, device 3, host.
- R2: `gnt_o` is one-hot or all-zero. Bit k stands for requester k, where bits 0 to 3 are devices 0 to 3 and bit 4 is the host. No grant appears when `req_i` is all-zero at the arbitration edge.
- R3: When the bus is free and device 0 requests at a clock edge, device 0 is granted from that edge, whatever the other requests and the history.
- R4: A grant, once given, is held unchanged until `xfer_done_i` is sampled high. New higher-priority requests and a dropped request of the owner do not change it.
- R5: When `xfer_done_i` is sampled high while a grant is active, `gnt_o` is zero from that edge on. The next grant can come at the following edge, and it is chosen from the order as updated by the release.
- R6: When a rotating requester releases the bus, it moves to the last place in the order and the others keep their relative order. For example, the order 2, 3, 1, host with device 3 released becomes 2, 1, host, 3.
- R7: A release by device 0 leaves the rotating order unchanged.
- R8: When the bus is free and device 0 is not requesting, the grant goes to the requesting rotating requester that stands earliest in the order.
- R9: `xfer_done_i` sampled while no grant is active has no effect on the grant or on the order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 5 | Request level per requester (bit 4 = host) |
| xfer_done_i | input | 1 | Current owner releases the bus |
| gnt_o | output | 5 | One-hot grant, all-zero when the bus is free |

## Verification
The bench steers the order into the state 2, 3, 1, host and then releases device 3. Next it reads the whole order back by requesting from all four rotating requesters over several rounds. A list that reinserted at the wrong slot, or that rotated like a pointer, would grant in a different sequence. It tests release by device 0, a done strobe while the bus is idle, and late high-priority requests during an owned transfer. Each of these catches a design that corrupts the list, acts on a stray strobe, or preempts the owner. It also holds the requests high across a release, which exposes a design that regrants in the same cycle or arbitrates from the stale order. Long random request and done patterns are compared cycle by cycle against a bench model of the order.

// File: rtl/hyb_arb_pkg.sv
package hyb_arb_pkg;
  localparam int unsigned NUM_REQ = 5;
  localparam int unsigned ROT_N   = NUM_REQ - 1;
  localparam int unsigned IDX_W   = $clog2(NUM_REQ);
  typedef logic [IDX_W-1:0] idx_t;
endpackage

// File: rtl/lru_order_list.sv
module lru_order_list
  import hyb_arb_pkg::*;
#(
  parameter int unsigned PIN_ID = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   upd_en_i,
  input  idx_t                   upd_id_i,
  output logic [ROT_N*IDX_W-1:0] slots_o
);
  localparam logic [NUM_REQ-1:0] ROT_MASK = ~(NUM_REQ'(1) << PIN_ID);

  idx_t             slot_q [ROT_N];
  logic [ROT_N-1:0] hit;

  // hit[i]: the released id sits at slot i or earlier, so slot i shifts up
  always_comb begin
    hit[0] = (slot_q[0] == upd_id_i);
    for (int i = 1; i < ROT_N; i++) begin
      hit[i] = hit[i-1] | (slot_q[i] == upd_id_i);
    end
  end

  for (genvar i = 0; i < ROT_N; i++) begin : g_slot
    localparam idx_t RST_ID = idx_t'((i < PIN_ID) ? i : i + 1);
    if (i == ROT_N - 1) begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 slot_q[i] <= RST_ID;
        else if (upd_en_i && hit[i]) slot_q[i] <= upd_id_i;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 slot_q[i] <= RST_ID;
        else if (upd_en_i && hit[i]) slot_q[i] <= slot_q[i+1];
      end
    end
    assign slots_o[i*IDX_W +: IDX_W] = slot_q[i];
  end

  logic [NUM_REQ-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < ROT_N; i++) seen = seen | (NUM_REQ'(1) << slot_q[i]);
  end

  // R6
  order_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen == ROT_MASK);

  // R6
  tail_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en_i |=> slot_q[ROT_N-1] == $past(upd_id_i));
endmodule

// File: rtl/fixed_lru_picker.sv
module fixed_lru_picker
  import hyb_arb_pkg::*;
#(
  parameter int unsigned PIN_ID = 0
) (
  input  logic [NUM_REQ-1:0]     req_i,
  input  logic [ROT_N*IDX_W-1:0] slots_i,
  output logic                   any_o,
  output idx_t                   pick_o
);
  always_comb begin
    any_o  = |req_i;
    pick_o = idx_t'(PIN_ID);
    for (int i = ROT_N - 1; i >= 0; i--) begin
      if (req_i[slots_i[i*IDX_W +: IDX_W]]) pick_o = slots_i[i*IDX_W +: IDX_W];
    end
    if (req_i[PIN_ID]) pick_o = idx_t'(PIN_ID);
  end
endmodule

// File: rtl/hybrid_bus_arbiter.sv
module hybrid_bus_arbiter
  import hyb_arb_pkg::*;
#(
  parameter int unsigned PIN_ID = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               xfer_done_i,
  output logic [NUM_REQ-1:0] gnt_o
);
  logic                   owner_vld_q;
  idx_t                   owner_id_q;
  logic                   any_req;
  idx_t                   pick_id;
  logic [ROT_N*IDX_W-1:0] slots;
  logic                   release_now;
  logic                   upd_en;

  assign release_now = owner_vld_q && xfer_done_i;
  assign upd_en      = release_now && (owner_id_q != idx_t'(PIN_ID));

  fixed_lru_picker #(.PIN_ID(PIN_ID)) i_picker (
    .req_i   (req_i),
    .slots_i (slots),
    .any_o   (any_req),
    .pick_o  (pick_id)
  );

  lru_order_list #(.PIN_ID(PIN_ID)) i_order (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en_i (upd_en),
    .upd_id_i (owner_id_q),
    .slots_o  (slots)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_vld_q <= 1'b0;
      owner_id_q  <= '0;
    end else if (release_now) begin
      owner_vld_q <= 1'b0;
    end else if (!owner_vld_q && any_req) begin
      owner_vld_q <= 1'b1;
      owner_id_q  <= pick_id;
    end
  end

  for (genvar k = 0; k < NUM_REQ; k++) begin : g_gnt
    assign gnt_o[k] = owner_vld_q && (owner_id_q == idx_t'(k));
  end

  // R2
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  // R2
  no_req_no_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o == '0 && req_i == '0) |=> gnt_o == '0);

  // R3
  pinned_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o == '0 && req_i[PIN_ID]) |=> gnt_o[PIN_ID]);

  // R4
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o != '0 && !xfer_done_i) |=> $stable(gnt_o));

  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o != '0 && xfer_done_i) |=> gnt_o == '0);

  // R7
  pinned_keeps_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o[PIN_ID] && xfer_done_i) |=> $stable(slots));

  // R9
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o == '0 && xfer_done_i) |=> $stable(slots));
endmodule

// File: tb/test_hybrid_bus_arbiter.sv
`timescale 1ns/1ps
module test_hybrid_bus_arbiter;
  localparam int  NREQ    = 5;
  localparam real CLK_PER = 5.0;
  localparam int  WD_CYC  = 100000;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NREQ-1:0] req;
  logic            done;
  logic [NREQ-1:0] gnt;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int m_owner;
  int m_ord [4];
  logic [NREQ-1:0] exp_gnt;

  always #(CLK_PER/2) clk = ~clk;

  hybrid_bus_arbiter i_hybrid_bus_arbiter (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req),
    .xfer_done_i (done),
    .gnt_o       (gnt)
  );

  function automatic int pick(input logic [NREQ-1:0] r);
    if (r[0]) return 0;
    for (int i = 0; i < 4; i++) if (r[m_ord[i]]) return m_ord[i];
    return -1;
  endfunction

  task automatic move_back(input int id);
    int pos = 0;
    for (int i = 0; i < 4; i++) if (m_ord[i] == id) pos = i;
    for (int i = pos; i < 3; i++) m_ord[i] = m_ord[i+1];
    m_ord[3] = id;
  endtask

  task automatic model_step(input logic [NREQ-1:0] r, input logic d);
    if (m_owner >= 0) begin
      if (d) begin
        if (m_owner != 0) move_back(m_owner);
        m_owner = -1;
      end
    end else begin
      m_owner = pick(r);
    end
    exp_gnt = (m_owner < 0) ? '0 : NREQ'(1) << m_owner;
  endtask

  task automatic check(input logic [NREQ-1:0] e, input string tag);
    checks++;
    if (gnt !== e) begin
      errors++;
      $display("FAIL %s gnt actual=%b expected=%b", tag, gnt, e);
    end
  endtask

  function automatic string auto_tag(input logic [NREQ-1:0] r, input logic d);
    if (m_owner >= 0) return d ? "R5" : "R4";
    if (d && r == '0) return "R9";
    if (r[0]) return "R3";
    if (r != '0) return "R8";
    return "R2";
  endfunction

  // drive at a falling edge, let the rising edge sample, check at next falling edge
  task automatic drv(input logic [NREQ-1:0] r, input logic d, input string tag);
    req  = r;
    done = d;
    model_step(r, d);
    @(negedge clk);
    check(exp_gnt, tag);
  endtask

  initial begin
    #(WD_CYC * CLK_PER);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R1..R9 actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; req = '0; done = 1'b0;
    m_owner = -1;
    m_ord[0] = 1; m_ord[1] = 2; m_ord[2] = 3; m_ord[3] = 4;
    repeat (3) @(negedge clk);
    check(5'b00000, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    check(5'b00000, "R1");

    // R1: reset order puts device 1 first among the rotating ones
    drv(5'b11110, 0, "R1"); check(5'b00010, "R1");
    drv(5'b00000, 1, "R5");                       // order 2,3,host,1
    drv(5'b10000, 0, "R8"); check(5'b10000, "R8");
    drv(5'b00000, 1, "R5");                       // order 2,3,1,host
    drv(5'b01000, 0, "R8"); check(5'b01000, "R8");
    drv(5'b00000, 1, "R6");                       // order 2,1,host,3
    // R6: read back the order through successive grants
    drv(5'b11110, 0, "R6"); check(5'b00100, "R6");
    drv(5'b11110, 1, "R6");
    drv(5'b11110, 0, "R6"); check(5'b00010, "R6");
    drv(5'b11110, 1, "R6");
    drv(5'b11110, 0, "R6"); check(5'b10000, "R6");
    drv(5'b11110, 1, "R6");
    drv(5'b11110, 0, "R6"); check(5'b01000, "R6");
    drv(5'b00000, 1, "R6");                       // order 2,1,host,3
    // R3 / R7: device 0 wins over all and its release keeps the order
    drv(5'b11111, 0, "R3"); check(5'b00001, "R3");
    drv(5'b00000, 1, "R7");
    drv(5'b11110, 0, "R7"); check(5'b00100, "R7");
    // R4: no preemption, owner keeps bus after dropping its request
    drv(5'b00001, 0, "R4"); check(5'b00100, "R4");
    drv(5'b00000, 0, "R4"); check(5'b00100, "R4");
    drv(5'b00000, 1, "R5"); check(5'b00000, "R5"); // order 1,host,3,2
    // R9: done while idle changes nothing
    drv(5'b00000, 1, "R9"); check(5'b00000, "R9");
    drv(5'b00000, 0, "R2"); check(5'b00000, "R2");
    drv(5'b11110, 0, "R9"); check(5'b00010, "R9");
    // R5: release with requests held gives one free cycle, then updated order
    drv(5'b11110, 1, "R5"); check(5'b00000, "R5"); // order host,3,2,1
    drv(5'b11110, 0, "R5"); check(5'b10000, "R5");
    drv(5'b00000, 1, "R5");

    // constrained random phase checked against the bench model
    for (int n = 0; n < 4000; n++) begin
      logic [NREQ-1:0] r;
      logic d;
      r = NREQ'($urandom);
      if (($urandom % 4) == 0) r[0] = 1'b0;
      if (($urandom % 8) == 0) r = '0;
      d = (($urandom % 3) == 0);
      drv(r, d, auto_tag(r, d));
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule